// File: doc/BRIEF.md
# One-Axis Subpixel Interpolation Filter

This block produces an 8x8 block of predicted pixels from an 8-bit reference window. It applies a 4-tap filter along one axis, horizontal or vertical, at a quarter, half or three-quarter pixel offset. A mode value of zero copies the reference pixels across unfiltered. Each filtered value is rounded, shifted, and limited to the pixel range. The result is then either written directly or averaged with a destination pixel that is supplied with the request.

A request is one handshake beat. It carries an 11x11 reference window, the 8x8 destination block, and the configuration: mode, axis, rounding bit and averaging enable. The block stores all of these when it accepts the beat. It then returns eight output rows, top to bottom, one row of eight pixels per beat on a valid/ready output. It takes no new request until the eighth row has been taken.

Top module: `subpel_filt8`

## Requirements
- R1: While reset is held and directly after it, `outValid` is 0 and `inReady` is 1.
- R2: A request is accepted on a clock edge where `inValid` and `inReady` are both 1. From the next cycle `outValid` is 1 and `inReady` is 0. Exactly 8 rows leave, row 0 first. Each row leaves on an edge with `outReady` high. After the eighth row, `outValid` is 0 and `inReady` is 1.
- R3: While `outValid` is 1 and `outReady` is 0, `outValid` stays 1 and `outPix` does not change.
- R4: For mode 1 (quarter offset), the taps on samples at axis positions -1, 0, +1, +2 are -4, 53, 18, -3. The result is (sum + 32 - rnd) >>> 6.
- R5: For mode 3 (three-quarter offset), the taps on positions -1, 0, +1, +2 are -3, 18, 53, -4. The result is (sum + 32 - rnd) >>> 6.
- R6: For mode 2 (half offset), the taps on positions -1, 0, +1, +2 are -1, 9, 9, -1. The result is (sum + 8 - rnd) >>> 4.
- R7: Every filtered result below 0 becomes 0, and every result above 255 becomes 255.
- R8: Mode 0 outputs the reference sample at position 0 unchanged.
- R9: Window sample (y, x), with y and x each in -1..9, is byte (y+1)*11+(x+1) of `inWin`, at bits [8k+7:8k]. Output pixel (r, c) uses the samples at (r, c-1..c+2) when `cfgVertical`=0, and at (r-1..r+2, c) when `cfgVertical`=1. Output row r carries pixel c in byte c of `outPix`.
- R10: With `cfgAvg`=1, each output pixel is (f + d + 1) >> 1. Here f is the limited filter result and d is byte r*8+c of `inDst`.
- R11: Changes to the window, destination or configuration inputs after acceptance have no effect on the block in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request present |
| inReady | output | 1 | Block is idle and can accept a request |
| inWin | input | 968 | 11x11 reference window, 8 bits per sample |
| inDst | input | 512 | 8x8 destination pixels for averaging |
| cfgMode | input | 2 | 0 copy, 1 quarter, 2 half, 3 three-quarter |
| cfgVertical | input | 1 | 1 filters along rows (vertical axis) |
| cfgRnd | input | 1 | Rounding control bit |
| cfgAvg | input | 1 | 1 averages with the destination |
| outValid | output | 1 | An output row is present |
| outReady | input | 1 | Consumer takes the row |
| outPix | output | 64 | Eight output pixels of the current row |

## Verification
The hard cases are the extreme sums: window content that drives the half- and quarter-offset sums below zero and above 255 on both axes. Random windows almost never produce them. The stimulus uses windows built from runs of two full-scale pixels followed by two zero pixels along both axes, which push the sums past both limits. It also uses an all-maximum window, which lands exactly on 255 after rounding. Separately, some blocks stall the consumer in mid-block. Other blocks keep `inValid` raised with scrambled inputs while a block is still being emitted, to show that the captured request is not disturbed.

// File: rtl/subpel_pkg.sv
package subpel_pkg;

  typedef enum logic [1:0] {
    MODE_COPY    = 2'd0,
    MODE_QUARTER = 2'd1,
    MODE_HALF    = 2'd2,
    MODE_THREEQ  = 2'd3
  } subpelMode_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;     // capture window, destination and configuration
    logic advance;  // current row consumed
  } ctrlStrobe_t;

  typedef struct packed {
    subpelMode_e mode;
    logic        vertical;
    logic        rnd;
    logic        avgEn;
  } blkCfg_t;

endpackage

// File: rtl/subpel_ctrl.sv
module subpel_ctrl
  import subpel_pkg::*;
#(
  parameter int BLK = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  output logic                    inReady,
  output logic                    outValid,
  input  logic                    outReady,
  output ctrlStrobe_t             strobe,
  output logic [$clog2(BLK)-1:0]  rowIdx
);
  localparam int ROW_W = $clog2(BLK);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(BLK - 1);

  logic busy;

  assign inReady        = !busy;
  assign outValid       = busy;
  assign strobe.load    = inValid && !busy;
  assign strobe.advance = busy && outReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      rowIdx <= '0;
    end else if (strobe.load) begin
      busy   <= 1'b1;
      rowIdx <= '0;
    end else if (strobe.advance) begin
      if (rowIdx == LAST_ROW) begin
        busy   <= 1'b0;
        rowIdx <= '0;
      end else begin
        rowIdx <= rowIdx + 1'b1;
      end
    end
  end

endmodule

// File: rtl/subpel_dp.sv
module subpel_dp
  import subpel_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int BLK   = 8,
  parameter int SUM_W = 16
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  ctrlStrobe_t                           strobe,
  input  logic [$clog2(BLK)-1:0]                rowIdx,
  input  logic [(BLK+3)*(BLK+3)*PIX_W-1:0]      inWin,
  input  logic [BLK*BLK*PIX_W-1:0]              inDst,
  input  blkCfg_t                               cfgIn,
  output logic [BLK*PIX_W-1:0]                  outPix
);
  localparam int WIN    = BLK + 3;
  localparam int NWIN   = WIN * WIN;
  localparam int NDST   = BLK * BLK;
  localparam int IDX_W  = $clog2(NWIN);
  localparam int DIDX_W = $clog2(NDST);
  localparam logic signed [SUM_W-1:0] K3      = SUM_W'(3);
  localparam logic signed [SUM_W-1:0] K4      = SUM_W'(4);
  localparam logic signed [SUM_W-1:0] K8      = SUM_W'(8);
  localparam logic signed [SUM_W-1:0] K9      = SUM_W'(9);
  localparam logic signed [SUM_W-1:0] K18     = SUM_W'(18);
  localparam logic signed [SUM_W-1:0] K32     = SUM_W'(32);
  localparam logic signed [SUM_W-1:0] K53     = SUM_W'(53);
  localparam logic signed [SUM_W-1:0] PIX_MAX = SUM_W'((1 << PIX_W) - 1);

  logic [PIX_W-1:0] winQ [NWIN];
  logic [PIX_W-1:0] dstQ [NDST];
  blkCfg_t          cfgQ;
  int               rowI;
  logic signed [SUM_W-1:0] rndS;

  always_ff @(posedge clk) begin
    if (strobe.load) begin
      for (int k = 0; k < NWIN; k++) winQ[k] <= inWin[k*PIX_W +: PIX_W];
      for (int k = 0; k < NDST; k++) dstQ[k] <= inDst[k*PIX_W +: PIX_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             cfgQ <= '0;
    else if (strobe.load)  cfgQ <= cfgIn;
  end

  assign rowI = int'(rowIdx);
  assign rndS = signed'(SUM_W'(cfgQ.rnd));

  for (genvar c = 0; c < BLK; c++) begin : g_col
    logic [PIX_W-1:0]        smp [4];
    logic signed [SUM_W-1:0] smpS [4];
    logic signed [SUM_W-1:0] acc;
    logic signed [SUM_W-1:0] rounded;
    logic [PIX_W-1:0]        filt;
    logic [PIX_W-1:0]        dPix;
    logic [PIX_W:0]          mixW;

    always_comb begin
      for (int k = 0; k < 4; k++) begin
        if (cfgQ.vertical) smp[k] = winQ[IDX_W'((rowI + k) * WIN + c + 1)];
        else               smp[k] = winQ[IDX_W'((rowI + 1) * WIN + c + k)];
        smpS[k] = signed'(SUM_W'(smp[k]));
      end
      unique case (cfgQ.mode)
        MODE_QUARTER: acc = K53 * smpS[1] + K18 * smpS[2] - K4 * smpS[0] - K3 * smpS[3];
        MODE_THREEQ:  acc = K53 * smpS[2] + K18 * smpS[1] - K4 * smpS[3] - K3 * smpS[0];
        MODE_HALF:    acc = K9 * (smpS[1] + smpS[2]) - smpS[0] - smpS[3];
        default:      acc = smpS[1];
      endcase
      if (cfgQ.mode == MODE_HALF) rounded = (acc + K8 - rndS) >>> 4;
      else                        rounded = (acc + K32 - rndS) >>> 6;
      if (cfgQ.mode == MODE_COPY)  filt = smp[1];
      else if (rounded < 0)        filt = '0;
      else if (rounded > PIX_MAX)  filt = '1;
      else                         filt = rounded[PIX_W-1:0];
      dPix = dstQ[DIDX_W'(rowI * BLK + c)];
      mixW = ({1'b0, filt} + {1'b0, dPix} + 1'b1) >> 1;
      outPix[c*PIX_W +: PIX_W] = cfgQ.avgEn ? PIX_W'(mixW) : filt;
    end
  end

endmodule

// File: rtl/subpel_filt8.sv
module subpel_filt8
  import subpel_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int BLK   = 8,
  parameter int SUM_W = 16
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              inValid,
  output logic                              inReady,
  input  logic [(BLK+3)*(BLK+3)*PIX_W-1:0]  inWin,
  input  logic [BLK*BLK*PIX_W-1:0]          inDst,
  input  logic [1:0]                        cfgMode,
  input  logic                              cfgVertical,
  input  logic                              cfgRnd,
  input  logic                              cfgAvg,
  output logic                              outValid,
  input  logic                              outReady,
  output logic [BLK*PIX_W-1:0]              outPix
);
  localparam int ROW_W = $clog2(BLK);

  ctrlStrobe_t      strobe;
  logic [ROW_W-1:0] rowIdx;
  blkCfg_t          cfgIn;

  assign cfgIn.mode     = subpelMode_e'(cfgMode);
  assign cfgIn.vertical = cfgVertical;
  assign cfgIn.rnd      = cfgRnd;
  assign cfgIn.avgEn    = cfgAvg;

  subpel_ctrl #(.BLK(BLK)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inReady  (inReady),
    .outValid (outValid),
    .outReady (outReady),
    .strobe   (strobe),
    .rowIdx   (rowIdx)
  );

  subpel_dp #(.PIX_W(PIX_W), .BLK(BLK), .SUM_W(SUM_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .rowIdx (rowIdx),
    .inWin  (inWin),
    .inDst  (inDst),
    .cfgIn  (cfgIn),
    .outPix (outPix)
  );

endmodule

// File: rtl/subpel_chk.sv
module subpel_chk #(
  parameter int PIX_W = 8,
  parameter int BLK   = 8
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   inValid,
  input logic                   inReady,
  input logic                   outValid,
  input logic                   outReady,
  input logic [BLK*PIX_W-1:0]   outPix
);
  localparam int CNT_W = $clog2(BLK);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BLK - 1);

  logic [CNT_W-1:0] beatCnt;

  always_ff @(posedge clk) begin
    if (!rstN)                     beatCnt <= '0;
    else if (inValid && inReady)   beatCnt <= '0;
    else if (outValid && outReady) beatCnt <= (beatCnt == LAST) ? '0 : beatCnt + 1'b1;
  end

  AST_BUSY_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !inReady); // R2
  AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> outValid); // R2
  AST_LAST_ROW_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && beatCnt == LAST) |=> (!outValid && inReady)); // R2
  AST_MID_ROW_CONTINUES: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && beatCnt != LAST) |=> outValid); // R2
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outPix))); // R3

endmodule

bind subpel_filt8 subpel_chk #(.PIX_W(PIX_W), .BLK(BLK)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inReady  (inReady),
  .outValid (outValid),
  .outReady (outReady),
  .outPix   (outPix)
);

// File: tb/test_subpel_filt8.sv
module test_subpel_filt8;
  localparam int CLK_PERIOD = 10;
  localparam int BLK = 8;
  localparam int WIN = BLK + 3;

  logic                     clk = 1'b0;
  logic                     rstN;
  logic                     inValid;
  logic                     inReady;
  logic [WIN*WIN*8-1:0]     inWin;
  logic [BLK*BLK*8-1:0]     inDst;
  logic [1:0]               cfgMode;
  logic                     cfgVertical, cfgRnd, cfgAvg;
  logic                     outValid;
  logic                     outReady;
  logic [BLK*8-1:0]         outPix;

  int checkCnt = 0;
  int failCnt  = 0;
  int winA [WIN*WIN];
  int dstA [BLK*BLK];
  logic [BLK*8-1:0] expRow [BLK];

  subpel_filt8 i_subpel_filt8 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inWin(inWin), .inDst(inDst), .cfgMode(cfgMode), .cfgVertical(cfgVertical),
    .cfgRnd(cfgRnd), .cfgAvg(cfgAvg), .outValid(outValid), .outReady(outReady),
    .outPix(outPix)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failCnt++;
    $display("FAIL R2 watchdog: actual run still busy, expected completion");
    finishRun();
  end

  task automatic checkVal(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // expected pixel from the requirement arithmetic
  function automatic int expPix(int r, int c, int mode, int vert, int rnd, int avg);
    int s [4];
    int sum, f;
    for (int k = 0; k < 4; k++)
      s[k] = vert ? winA[(r + k) * WIN + c + 1] : winA[(r + 1) * WIN + c + k];
    case (mode)
      1: begin sum = -4*s[0] + 53*s[1] + 18*s[2] - 3*s[3]; f = (sum + 32 - rnd) >>> 6; end // R4
      3: begin sum = -3*s[0] + 18*s[1] + 53*s[2] - 4*s[3]; f = (sum + 32 - rnd) >>> 6; end // R5
      2: begin sum = -s[0] + 9*s[1] + 9*s[2] - s[3];       f = (sum + 8 - rnd) >>> 4;  end // R6
      default: f = s[1];                                                                // R8
    endcase
    if (f < 0) f = 0;        // R7
    if (f > 255) f = 255;    // R7
    if (avg != 0) f = (f + dstA[r * BLK + c] + 1) >> 1; // R10
    return f;
  endfunction

  task automatic fillWindow(input int pat);
    for (int y = -1; y < WIN - 1; y++)
      for (int x = -1; x < WIN - 1; x++) begin
        int v;
        case (pat)
          0: v = int'($urandom_range(255));
          1: v = ((((x + 1) >> 1) + ((y + 1) >> 1)) & 1) != 0 ? 255 : 0;
          2: v = 255;
          default: v = ((x + 1) * 23 + (y + 1) * 7) % 256;
        endcase
        winA[(y + 1) * WIN + (x + 1)] = v;
      end
    for (int k = 0; k < BLK*BLK; k++) dstA[k] = int'($urandom_range(255));
    for (int k = 0; k < WIN*WIN; k++) inWin[k*8 +: 8] = 8'(winA[k]);
    for (int k = 0; k < BLK*BLK; k++) inDst[k*8 +: 8] = 8'(dstA[k]);
  endtask

  task automatic runBlock(input int pat, input int mode, input int vert, input int rnd,
                          input int avg, input bit stall, input bit scramble);
    string tag;
    fillWindow(pat);
    for (int r = 0; r < BLK; r++)
      for (int c = 0; c < BLK; c++)
        expRow[r][c*8 +: 8] = 8'(expPix(r, c, mode, vert, rnd, avg));
    case (mode)
      1: tag = "R4";
      2: tag = "R6";
      3: tag = "R5";
      default: tag = "R8";
    endcase
    tag = $sformatf("%s R9%s%s%s m%0d v%0d rnd%0d", tag, (pat == 1 || pat == 2) ? " R7" : "",
                    avg != 0 ? " R10" : "", scramble ? " R11" : "", mode, vert, rnd);
    cfgMode = 2'(mode); cfgVertical = vert[0]; cfgRnd = rnd[0]; cfgAvg = avg[0];
    checkVal("R2 idle before request", {63'd0, inReady}, 64'd1);
    inValid = 1'b1;
    @(posedge clk); @(negedge clk);
    inValid = scramble;
    if (scramble) begin
      for (int k = 0; k < WIN*WIN*8; k += 32) inWin[k +: 8] = 8'($urandom_range(255));
      inDst = ~inDst; cfgMode = ~cfgMode; cfgVertical = ~cfgVertical;
      cfgRnd = ~cfgRnd; cfgAvg = ~cfgAvg;
    end
    for (int r = 0; r < BLK; r++) begin
      if (stall && r == 3) begin
        outReady = 1'b0;
        @(posedge clk); @(negedge clk);
        checkVal($sformatf("R3 stalled row %0d", r), {63'd0, outValid}, 64'd1);
        checkVal($sformatf("R3 stalled row %0d data", r), outPix, expRow[r]);
        outReady = 1'b1;
      end
      if (r == 0) checkVal("R2 busy refuses requests", {63'd0, inReady}, 64'd0);
      checkVal($sformatf("R2 valid row %0d", r), {63'd0, outValid}, 64'd1);
      checkVal($sformatf("%s row %0d", tag, r), outPix, expRow[r]);
      @(posedge clk); @(negedge clk);
      if (r == 0) inValid = 1'b0;
    end
    checkVal("R2 idle after eighth row", {62'd0, outValid, inReady}, 64'd1);
  endtask

  initial begin
    int blkNo;
    rstN = 1'b0; inValid = 1'b0; outReady = 1'b1;
    inWin = '0; inDst = '0; cfgMode = '0; cfgVertical = 1'b0; cfgRnd = 1'b0; cfgAvg = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkVal("R1 reset state", {62'd0, outValid, inReady}, 64'd1);
    rstN = 1'b1;
    @(negedge clk);
    checkVal("R1 after reset", {62'd0, outValid, inReady}, 64'd1);
    blkNo = 0;
    for (int pat = 0; pat < 4; pat++)
      for (int mode = 0; mode < 4; mode++)
        for (int vert = 0; vert < 2; vert++)
          for (int rnd = 0; rnd < 2; rnd++)
            for (int avg = 0; avg < 2; avg++) begin
              runBlock(pat, mode, vert, rnd, avg, (blkNo % 3) == 0, (blkNo % 5) == 1);
              blkNo++;
            end
    finishRun();
  end

endmodule